// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block takes register writes from a slow three-wire control link and applies them to a local bank of 128 byte-wide registers. The three lines are an active-low frame select, a bit clock and a serial data line. None of them is related to the system clock. All three are brought into the system clock domain, and their edges are found there.

A frame begins when the select line falls. The data line is sampled once at each rising bit-clock edge while select is low, most significant bit first. When select returns high, the block judges the frame. Exactly sixteen sampled bits with a zero leading bit make a valid frame. For a valid frame the low byte is stored at the 7-bit address held in the middle bits, and a one-cycle write strobe shows the address and byte to the host. Any other frame is dropped and marked with a one-cycle error pulse. The host can read the register bank at any time through a separate address input with a registered data output.

Top module: `tw_regport`

## Requirements
- R1: A frame is 16 bits sent most significant bit first. Bit 15 is a reserved flag. Bits 14..8 are the register address and bits 7..0 are the data byte.
- R2: If select rises after exactly 16 sampled bits and bit 15 is 0, the byte is stored at the address. In the same window, `wr_stb` is high for one cycle with `wr_idx` and `wr_data` valid. This happens within 4 system clock cycles of select rising at the pin.
- R3: A 16-bit frame with bit 15 set writes nothing. It raises `err_stb` for one cycle and leaves `wr_idx`/`wr_data` unchanged.
- R4: A frame of any length other than 16 bits writes nothing and raises `err_stb` for one cycle.
- R5: `wr_stb` and `err_stb` are each high for one cycle per frame, and they are never high together.
- R6: A falling select clears the bit count and the shifted bits, so an aborted short frame has no effect on the next frame.
- R7: While `rst` is high and on the cycle after it, all registers read as zero and both strobes are low.
- R8: After reset, a frame is accepted only if select was first seen high. A frame already in progress when reset ends causes neither a write nor an error.
- R9: `rd_data` shows the register at `rd_idx` one cycle later. A read in the same cycle as a committed write to that address returns the old content, and the cycle after returns the new byte.
- R10: Bit-clock edges while select is high are ignored and add no bits to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Frame select, active low, idles high |
| sclk | input | 1 | Serial bit clock, asynchronous |
| sdat | input | 1 | Serial data, sampled on rising `sclk` |
| rd_idx | input | 7 | Host read address |
| rd_data | output | 8 | Registered read data |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_idx | output | 7 | Committed address, valid with `wr_stb` |
| wr_data | output | 8 | Committed byte, valid with `wr_stb` |
| err_stb | output | 1 | One-cycle pulse for a rejected frame |

## Verification
A host read and a serial commit to the same address can fall in the same clock cycle. To provoke this, the bench holds `rd_idx` on the target address while a frame for that address finishes. It then watches for `wr_stb` and samples `rd_data` on the next two cycles. The first sample must be the old byte and the second must be the new one. Over the many random frames, the bench also judges whether commit and reject ever overlap: each frame must produce exactly one of the two pulses.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DEF_IDX_W = 7;
  localparam int DEF_DAT_W = 8;

  typedef enum logic [1:0] {
    END_NONE   = 2'd0,
    END_COMMIT = 2'd1,
    END_REJECT = 2'd2
  } frame_end_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  // reset value 0: select must be seen high after reset before a frame can open
  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_deser.sv
module tw_deser
  import tw_pkg::*;
#(
  parameter int IDX_W = DEF_IDX_W,
  parameter int DAT_W = DEF_DAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_s,
  input  logic             sclk_s,
  input  logic             sdat_s,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DAT_W-1:0] wr_data,
  output logic             err_stb
);
  localparam int WORD_W  = 1 + IDX_W + DAT_W;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_MAX = WORD_W + 1;

  logic              sel_d, sclk_d, in_word;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              sel_fall, sel_rise, sclk_rise;
  frame_end_e        fin;

  assign sel_fall  = sel_d & ~sel_s;
  assign sel_rise  = ~sel_d & sel_s;
  assign sclk_rise = ~sclk_d & sclk_s;

  always_comb begin
    fin = END_NONE;
    if (in_word && sel_rise) begin
      if (cnt == CNT_W'(WORD_W) && !shreg[WORD_W-1]) fin = END_COMMIT;
      else                                          fin = END_REJECT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d   <= 1'b0;
      sclk_d  <= 1'b0;
      in_word <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      wr_stb  <= 1'b0;
      err_stb <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      sel_d   <= sel_s;
      sclk_d  <= sclk_s;
      wr_stb  <= (fin == END_COMMIT);
      err_stb <= (fin == END_REJECT);
      if (fin == END_COMMIT) begin
        wr_idx  <= shreg[WORD_W-2 -: IDX_W];
        wr_data <= shreg[DAT_W-1:0];
      end
      if (sel_fall) begin
        in_word <= 1'b1;
        cnt     <= '0;
        shreg   <= '0;
      end else if (in_word && !sel_s && sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (sel_rise) in_word <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int IDX_W = 7,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [DAT_W-1:0] w_data,
  input  logic [IDX_W-1:0] r_idx,
  output logic [DAT_W-1:0] r_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];
  logic [DAT_W-1:0] mem_q;
  logic [DEPTH-1:0] vld;
  logic             vld_q;

  // storage array: no reset, read-before-write, suits block RAM
  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
    mem_q <= mem[r_idx];
  end

  // per-entry written flags give the reset-to-zero view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (we) vld[w_idx] <= 1'b1;
      vld_q <= vld[r_idx];
    end
  end

  assign r_data = vld_q ? mem_q : '0;
endmodule

// File: rtl/tw_regport.sv
module tw_regport
  import tw_pkg::*;
#(
  parameter int IDX_W       = DEF_IDX_W,
  parameter int DAT_W       = DEF_DAT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdat,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DAT_W-1:0] rd_data,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DAT_W-1:0] wr_data,
  output logic             err_stb
);
  logic [2:0] pins_s;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_n, sclk, sdat}),
    .q   (pins_s)
  );

  tw_deser #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_deser (
    .clk     (clk),
    .rst     (rst),
    .sel_s   (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdat_s  (pins_s[0]),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .err_stb (err_stb)
  );

  tw_regfile #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_stb),
    .w_idx  (wr_idx),
    .w_data (wr_data),
    .r_idx  (rd_idx),
    .r_data (rd_data)
  );
endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
  parameter int IDX_W = 7,
  parameter int DAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic [DAT_W-1:0] wr_data,
  input logic [IDX_W-1:0] wr_idx,
  input logic             err_stb
);
  // R5
  stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && err_stb));

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_stb |=> !err_stb);

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_stb |-> ($stable(wr_data) && $stable(wr_idx)));

  // R7
  post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_stb && !err_stb));
endmodule

bind tw_regport tw_regport_chk #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_stb  (wr_stb),
  .wr_data (wr_data),
  .wr_idx  (wr_idx),
  .err_stb (err_stb)
);

// File: tb/tw_regport_bench.sv
module tw_regport_bench;
  localparam int CLK_P = 10;
  localparam int HB    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdat = 1'b0;
  logic [6:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       wr_stb, err_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_err = 0;
  int stb_cnt = 0;
  int err_cnt = 0;
  logic [6:0] last_idx;
  logic [7:0] last_data;
  logic [7:0] exp_mem [128];
  logic [7:0] rdw_old, rdw_new;
  bit rdw_seen;

  always #(CLK_P/2) clk = ~clk;

  tw_regport u_tw_regport (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .err_stb(err_stb)
  );

  always @(negedge clk) begin
    if (wr_stb)  begin stb_cnt++; last_idx = wr_idx; last_data = wr_data; end
    if (err_stb) err_cnt++;
  end

  function automatic bit frame_ok(input logic [15:0] w, input int n);
    return (n == 16) && !w[15];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sdat = b;
    repeat (HB) @(negedge clk);
    sclk = 1'b1;
    repeat (HB) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [15:0] w, input int n, input bit watch);
    sel_n = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < n; i++) bit_out(i < 16 ? w[15-i] : 1'($urandom));
    repeat (HB) @(negedge clk);
    sel_n = 1'b1;
    rdw_seen = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (watch && !rdw_seen && wr_stb) begin
        rdw_seen = 1'b1;
        @(negedge clk); rdw_old = rd_data;
        @(negedge clk); rdw_new = rd_data;
      end
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n, input string tag);
    int s0 = stb_cnt;
    int e0 = err_cnt;
    bit ok = frame_ok(w, n);
    send(w, n, 1'b0);
    chk(stb_cnt - s0 == (ok ? 1 : 0), {tag, " strobe count"}, stb_cnt - s0, ok ? 1 : 0);
    chk(err_cnt - e0 == (ok ? 0 : 1), {tag, " error count"}, err_cnt - e0, ok ? 0 : 1);
    if (ok) begin
      chk(last_idx == w[14:8], {tag, " wr_idx"}, last_idx, w[14:8]);
      chk(last_data == w[7:0], {tag, " wr_data"}, last_data, w[7:0]);
      exp_mem[w[14:8]] = w[7:0];
    end
  endtask

  task automatic rd_chk(input logic [6:0] a, input string tag);
    rd_idx = a;
    @(negedge clk);
    chk(rd_data == exp_mem[a], tag, rd_data, exp_mem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    foreach (exp_mem[i]) exp_mem[i] = 8'h00;
    // R8: select held low through reset
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R7: outputs quiet right after reset
    chk(!wr_stb && !err_stb, "R7 strobes low after reset", {wr_stb, err_stb}, 0);
    rd_chk(7'h00, "R7 reg 00 zero");
    rd_chk(7'h7f, "R7 reg 7f zero");
    rd_chk(7'h2a, "R7 reg 2a zero");
    // R8: frame in progress at reset release is ignored
    begin
      int s0 = stb_cnt;
      int e0 = err_cnt;
      for (int i = 0; i < 16; i++) bit_out(i >= 8);
      repeat (HB) @(negedge clk);
      sel_n = 1'b1;
      repeat (16) @(negedge clk);
      chk(stb_cnt == s0, "R8 no strobe for unarmed frame", stb_cnt - s0, 0);
      chk(err_cnt == e0, "R8 no error for unarmed frame", err_cnt - e0, 0);
      rd_chk(7'h00, "R8 reg 00 untouched");
    end
    // R1 R2: directed valid frames, address 0x55 data 0xa3
    frame(16'h55a3, 16, "R1 R2 directed");
    rd_chk(7'h55, "R2 reg 55 readback");
    frame(16'h7fff, 16, "R2 top index");
    rd_chk(7'h7f, "R2 reg 7f readback");
    // R3: top bit set
    frame(16'hd5cc, 16, "R3 top bit set");
    rd_chk(7'h55, "R3 reg 55 unchanged");
    // R4: wrong lengths
    frame(16'h1234, 15, "R4 fifteen bits");
    frame(16'h1234, 17, "R4 seventeen bits");
    frame(16'h1234, 0, "R4 empty frame");
    rd_chk(7'h12, "R4 reg 12 unchanged");
    // R6: aborted short frame then a clean one
    frame(16'hffff, 5, "R6 aborted");
    frame(16'h0911, 16, "R6 clean frame");
    rd_chk(7'h09, "R6 reg 09 readback");
    // R10: bit clock toggles with select high
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    frame(16'h3a5c, 16, "R10 after idle pulses");
    rd_chk(7'h3a, "R10 reg 3a readback");
    // R9: read collides with commit to the same address
    rd_idx = 7'h3a;
    @(negedge clk);
    send(16'h3ac7, 16, 1'b1);
    chk(rdw_seen, "R9 commit observed", rdw_seen, 1);
    chk(rdw_old == 8'h5c, "R9 old value on colliding read", rdw_old, 8'h5c);
    chk(rdw_new == 8'hc7, "R9 new value next cycle", rdw_new, 8'hc7);
    exp_mem[7'h3a] = 8'hc7;
    // random mix: R2 R3 R4 R5
    for (int t = 0; t < 60; t++) begin
      logic [15:0] w;
      int r, n;
      w = 16'($urandom);
      w[15] = ($urandom % 5 == 0);
      r = $urandom % 8;
      n = (r == 6) ? 15 : (r == 7) ? 17 : 16;
      if ($urandom % 4 == 0) for (int j = 0; j < 2; j++) bit_out(1'($urandom));
      frame(w, n, "R5 random frame");
    end
    // full sweep of the bank
    for (int a = 0; a < 128; a++) rd_chk(7'(a), "R2 sweep");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule